// File: doc/BRIEF.md
# Streaming Data Bus Grant Scheduler

This block sits on the system side of a shared data bus. It issues data bus grants to four bus masters that run in a streaming mode. In that mode a master starts its data tenure on the grant alone and never looks at the bus-busy line. Every master raises a transfer-start strobe when it launches a transaction. A strobe that is not flagged as address-only counts as a request for one data tenure. Along with the strobe comes a size bit that selects either a single-beat tenure or a four-beat burst. Each master's requests wait in a small queue of their own, in the order they arrived.

Because the masters ignore bus-busy, the scheduler alone keeps tenures apart. A grant is a pulse exactly one cycle wide, given in the cycle just before its tenure starts. A grant in cycle t gives the bus to its master for cycles t+1 through t+B, where B is the tenure's beat count. The scheduler counts down the running tenure itself. It gives the next grant in the last beat's cycle, so tenures follow each other with no idle cycle and no overlap. The one exception is a single-beat tenure: the next grant then waits one more cycle, so that grants never fall in consecutive cycles. Masters take turns in round-robin order. A guard output pulses if the grant vector ever breaks the one-pulse rules.

Top module: `sdg_grant_gen`

## Requirements
- R1: At most one bit of `grant_o` is high in any cycle, and no grant is given in the cycle directly after a grant.
- R2: A request accepted at the clock edge that ends cycle c can be granted no earlier than cycle c+1. It is granted in c+1 when the bus is free and no other master is ahead of it.
- R3: A transfer-start strobe with its `addr_only_i` bit high creates no request and never leads to a grant.
- R4: A request whose `burst_i` bit was 1 gives a 4-beat tenure. If a grant for it is given in cycle t, the next grant comes no earlier than cycle t+4, and in exactly cycle t+4 when some request is pending.
- R5: A request whose `burst_i` bit was 0 gives a 1-beat tenure. If a grant for it is given in cycle t, the next grant comes no earlier than cycle t+2, and in exactly cycle t+2 when some request is pending.
- R6: When the bus is free, the search for the next grant starts at the master one above the last granted index, counts upward and wraps from 3 to 0. Master 0 has first turn after reset.
- R7: Each master's requests are granted in the order they arrived. Every grant uses the size bit captured with its own request.
- R8: Each master holds at most 4 pending requests. A request that arrives while 4 are pending is dropped, even when the same cycle grants one of them.
- R9: `err_o` stays low for as long as R1 holds. It pulses in any cycle where two grant bits are high together, or where a grant follows the grant of the previous cycle.
- R10: While `rst` is high and in the first cycle after it, `grant_o` and `err_o` are zero and no requests are pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ts_i | input | 4 | Transfer-start strobe, one bit per master |
| addr_only_i | input | 4 | Marks the strobe as address-only (no data tenure) |
| burst_i | input | 4 | Size of the requested tenure: 1 = four beats, 0 = one beat |
| grant_o | output | 4 | One-cycle data bus grant, one bit per master |
| err_o | output | 1 | Guard pulse on a malformed grant pattern |

## Verification
The bench keeps its own model of each master's queue, the turn order and the spacing window, and checks every cycle's grant against it. It also checks the one-pulse rules on their own. It aims at the corners: a single-beat tenure, which a naive countdown would follow with a grant in the very next cycle; a fifth request that lands in the same cycle as a grant while the queue is full, which a scheduler that checks room after the grant would wrongly keep; and address-only strobes, which a loose decoder would turn into phantom grants. A full sweep over every request pattern and size mix exposes a round-robin pointer that skips or repeats a master, and a burst that ends one beat early or late.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

    typedef enum logic {
        SZ_SINGLE = 1'b0,
        SZ_BURST  = 1'b1
    } sdg_size_e;

    typedef struct packed {
        logic      valid;
        sdg_size_e size;
    } sdg_head_t;

    function automatic int unsigned sdg_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdg_req_queue.sv
module sdg_req_queue
    import sdg_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push_i,
    input  sdg_size_e size_i,
    input  logic      pop_i,
    output sdg_head_t head_o
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    sdg_size_e        slots [DEPTH];
    logic [PW-1:0]    rd_ptr_q, wr_ptr_q;
    logic [CW-1:0]    cnt_q;
    logic             full, accept;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign full   = (cnt_q == CW'(DEPTH));
    assign accept = push_i && !full;

    always_ff @(posedge clk) begin
        if (accept) slots[wr_ptr_q] <= size_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (accept) wr_ptr_q <= bump(wr_ptr_q);
            if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
            case ({accept, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_o.valid = (cnt_q != '0);
    assign head_o.size  = slots[rd_ptr_q];

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> (cnt_q != '0));

endmodule

// File: rtl/sdg_rr_pick.sv
module sdg_rr_pick #(
    parameter int unsigned NUM_M = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_M-1:0] valid_i,
    input  logic             fire_i,
    output logic [NUM_M-1:0] gnt_o
);
    localparam int unsigned IW = (NUM_M > 1) ? $clog2(NUM_M) : 1;

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] win_idx;
    logic          found;

    always_comb begin
        int idx;
        gnt_o   = '0;
        found   = 1'b0;
        win_idx = '0;
        for (int k = 0; k < NUM_M; k++) begin
            idx = (int'(ptr_q) + k) % NUM_M;
            if (!found && valid_i[idx]) begin
                found   = 1'b1;
                win_idx = IW'(idx);
                gnt_o[idx] = fire_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (found && fire_i) begin
            if (int'(win_idx) == NUM_M - 1) ptr_q <= '0;
            else                           ptr_q <= win_idx + 1'b1;
        end
    end

    p_gnt_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        ((gnt_o & ~valid_i) == '0));

endmodule

// File: rtl/sdg_tenure_timer.sv
module sdg_tenure_timer
    import sdg_pkg::*;
#(
    parameter int unsigned SHORT_BEATS = 1,
    parameter int unsigned LONG_BEATS  = 4,
    parameter int unsigned MIN_GAP     = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  sdg_size_e size_i,
    output logic      ready_o
);
    localparam int unsigned SPAN_S   = sdg_max(SHORT_BEATS, MIN_GAP);
    localparam int unsigned SPAN_L   = sdg_max(LONG_BEATS, MIN_GAP);
    localparam int unsigned SPAN_MAX = sdg_max(SPAN_S, SPAN_L);
    localparam int unsigned HW       = $clog2(SPAN_MAX);

    logic [HW-1:0] gap_left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_left_q <= '0;
        end else if (start_i) begin
            gap_left_q <= (size_i == SZ_BURST) ? HW'(SPAN_L - 1) : HW'(SPAN_S - 1);
        end else if (gap_left_q != '0) begin
            gap_left_q <= gap_left_q - 1'b1;
        end
    end

    assign ready_o = (gap_left_q == '0);

    p_start_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
        start_i |-> (gap_left_q == '0));

endmodule

// File: rtl/sdg_grant_gen.sv
module sdg_grant_gen
    import sdg_pkg::*;
#(
    parameter int unsigned NUM_M       = 4,
    parameter int unsigned QDEPTH      = 4,
    parameter int unsigned SHORT_BEATS = 1,
    parameter int unsigned LONG_BEATS  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_M-1:0] ts_i,
    input  logic [NUM_M-1:0] addr_only_i,
    input  logic [NUM_M-1:0] burst_i,
    output logic [NUM_M-1:0] grant_o,
    output logic             err_o
);
    localparam int unsigned MIN_GAP = 2;

    sdg_head_t        heads [NUM_M];
    logic [NUM_M-1:0] pending;
    logic             bus_ready;
    logic             any_grant;
    sdg_size_e        grant_size;
    logic             prev_grant_q;

    for (genvar g = 0; g < NUM_M; g++) begin : g_queue
        sdg_req_queue #(.DEPTH(QDEPTH)) u_queue (
            .clk    (clk),
            .rst    (rst),
            .push_i (ts_i[g] && !addr_only_i[g]),
            .size_i (sdg_size_e'(burst_i[g])),
            .pop_i  (grant_o[g]),
            .head_o (heads[g])
        );
        assign pending[g] = heads[g].valid;
    end

    sdg_rr_pick #(.NUM_M(NUM_M)) u_pick (
        .clk     (clk),
        .rst     (rst),
        .valid_i (pending),
        .fire_i  (bus_ready),
        .gnt_o   (grant_o)
    );

    always_comb begin
        grant_size = SZ_SINGLE;
        for (int i = 0; i < NUM_M; i++) begin
            if (grant_o[i] && heads[i].size == SZ_BURST) grant_size = SZ_BURST;
        end
    end

    assign any_grant = |grant_o;

    sdg_tenure_timer #(
        .SHORT_BEATS (SHORT_BEATS),
        .LONG_BEATS  (LONG_BEATS),
        .MIN_GAP     (MIN_GAP)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (any_grant),
        .size_i  (grant_size),
        .ready_o (bus_ready)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_grant_q <= 1'b0;
        else     prev_grant_q <= any_grant;
    end

    assign err_o = (any_grant && prev_grant_q) || ($countones(grant_o) > 1);

    p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    p_no_repeat_r1: assert property (@(posedge clk) disable iff (rst)
        any_grant |=> !any_grant);

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !err_o);

endmodule

// File: tb/tb_sdg_grant_gen.sv
`timescale 1ns/1ps
module tb_sdg_grant_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ts_i = '0, addr_only_i = '0, burst_i = '0;
    logic [3:0] grant_o;
    logic       err_o;

    int checks = 0;
    int fails  = 0;

    // bench-side model state
    int mc [4];
    int mh [4];
    bit ms [4][4];
    int ptr  = 0;
    int hold = 0;
    bit prev_g = 0;
    int g2_count = 0;
    int g_total = 0;

    always #2.5 clk = ~clk;

    sdg_grant_gen dut (
        .clk(clk), .rst(rst), .ts_i(ts_i), .addr_only_i(addr_only_i),
        .burst_i(burst_i), .grant_o(grant_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [3:0] ts, input logic [3:0] ao, input logic [3:0] bu,
                        input string tag);
        logic [3:0] exp_g;
        int w;
        bit acc [4];
        ts_i = ts; addr_only_i = ao; burst_i = bu;
        #0.5;
        exp_g = '0; w = -1;
        if (hold == 0) begin
            for (int k = 0; k < 4; k++) begin
                int idx;
                idx = (ptr + k) % 4;
                if (w < 0 && mc[idx] > 0) begin
                    w = idx;
                    exp_g[idx] = 1'b1;
                end
            end
        end
        check(grant_o == exp_g, tag, grant_o, exp_g);
        check($countones(grant_o) <= 1 && !(prev_g && grant_o != 0), "R1", grant_o, 0);
        check(err_o == 1'b0, "R9", err_o, 0);
        prev_g = (grant_o != 0);
        if (grant_o[2]) g2_count++;
        if (grant_o != 0) g_total++;
        for (int m = 0; m < 4; m++) acc[m] = ts[m] && !ao[m] && (mc[m] < 4);
        if (w >= 0) begin
            bit lng;
            lng = ms[w][mh[w]];
            mh[w] = (mh[w] + 1) % 4;
            mc[w]--;
            hold = lng ? 3 : 1;
            ptr = (w + 1) % 4;
        end else if (hold > 0) begin
            hold--;
        end
        for (int m = 0; m < 4; m++) begin
            if (acc[m]) begin
                ms[m][(mh[m] + mc[m]) % 4] = bu[m];
                mc[m]++;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(4'h0, 4'h0, 4'h0, tag);
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int m = 0; m < 4; m++) begin mc[m] = 0; mh[m] = 0; end
        repeat (3) @(negedge clk);
        check(grant_o == 0, "R10", grant_o, 0);
        check(err_o == 0, "R10", err_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(grant_o == 0 && err_o == 0, "R10", grant_o, 0);

        // R2 and R4: single burst, then queued bursts spaced by 4
        step(4'b0001, 4'h0, 4'b0001, "R2");
        idle(6, "R4");
        step(4'b0011, 4'h0, 4'b0011, "R4");
        idle(12, "R4");

        // R5: single-beat tenures spaced by two cycles
        step(4'b1111, 4'h0, 4'h0, "R5");
        step(4'b1111, 4'h0, 4'h0, "R5");
        idle(20, "R5");

        // R3: address-only strobes must create nothing
        g_total = 0;
        step(4'b1111, 4'b1111, 4'b1010, "R3");
        step(4'b0101, 4'b0101, 4'b0000, "R3");
        idle(10, "R3");
        check(g_total == 0, "R3", g_total, 0);

        // R6: all masters at once, rotation order
        step(4'b1111, 4'h0, 4'b1111, "R6");
        idle(20, "R6");

        // R7: mixed sizes on one master keep their order
        step(4'b0010, 4'h0, 4'b0010, "R7");
        step(4'b0010, 4'h0, 4'b0000, "R7");
        step(4'b0010, 4'h0, 4'b0010, "R7");
        step(4'b0010, 4'h0, 4'b0000, "R7");
        idle(20, "R7");

        // R8: five requests while the bus is busy; exactly four survive
        g2_count = 0;
        step(4'b0001, 4'h0, 4'b0001, "R8");
        for (int i = 0; i < 5; i++) step(4'b0100, 4'h0, 4'b0100, "R8");
        idle(30, "R8");
        check(g2_count == 4, "R8", g2_count, 4);

        // R6 sweep over every request pattern and size mix
        for (int p = 1; p < 16; p++) begin
            for (int b = 0; b < 16; b++) begin
                step(4'(p), 4'(b & ~p & 4'hF), 4'(b), "R6");
                idle(18, "R6");
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule